// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is a memory-mapped master for a single open-drain one-wire line. A host talks to it through five byte-wide registers: a command register, a data register, an interrupt status register, an interrupt enable register and a clock divisor register. It can issue a bus reset and record whether any slave answered with a presence pulse. It can also move a byte across the line as eight time slots, sending the least significant bit first and capturing the line level of each slot into a receive byte.

To read a byte from a slave, the host writes 0xFF. Every slot then becomes a short "release" slot, and the byte returned is the level that the slave left on the line in each slot. All bus timing is counted in ticks of an internal time base, nominally 1 us. That time base is derived from the system clock through the divisor register. A level interrupt output with programmable polarity summarises the enabled status flags.

Top module: `owm_ctrl`

## Requirements
- R1: The register index is `addr >> ADDR_SHIFT`, and the low address bits are ignored. Index 0 is command, 1 is data, 2 is interrupt status, 3 is interrupt enable and 4 is clock divisor. Indices 5 to 7 read 0. The divisor register keeps only bits [4:0].
- R2: After reset, status reads 0x0E and the divisor and enable registers read 0. `irq_o` is high because the output is active-low with no sources enabled.
- R3: Writing command bit 0 = 1 starts a bus reset. The line is pulled low for T_RST_LOW ticks and then released for T_RST_HIGH ticks. Command bit 0 reads 1 from the write until the sequence ends.
- R4: The line is sampled T_PD_SMP ticks after release. At T_PD_DONE ticks after release, status bit 0 (presence done) is set, and status bit 1 is loaded with the sampled level: 0 means a slave answered and 1 means none did. Status bit 1 keeps that value until the next bus reset.
- R5: Reading the status register clears status bit 0 only.
- R6: Writing the data register sends the byte LSB first. A 0 bit pulls the line low for T_W0 ticks and a 1 bit for T_W1 ticks. Each slot lasts T_SLOT+T_REC ticks.
- R7: Each slot samples the line T_SMP ticks after it starts. The eight samples form the received byte, LSB first, which is read back from the data register. Writing 0xFF therefore returns the slave's byte.
- R8: The status flags are: bit 2 TX buffer empty, bit 3 TX shift idle, bit 4 RX buffer full and bit 5 RX shift register full. A completed byte goes to the RX buffer if that buffer is empty; otherwise it stays in the shift register and sets bit 5. A data read returns the buffer and then refills it from the shift register. No new byte starts while bit 5 is set.
- R9: `irq_o` is the OR of the status bits 0, 2, 3, 4 and 5 that are enabled by the matching enable bits. Enable bit 1 = 1 makes the output active-high; 0 makes it active-low.
- R10: Divisor bits [2:0] = N and bits [4:3] = P. One tick lasts (N+1)·2^P clocks. The tick counter restarts at the start of every sequence.
- R11: Command bit 7 = 1 selects overdrive, which shifts every timing interval right by OD_SHIFT.
- R12: Command bit 2 pulls the line low only while enable bit 6 is set. Command bit 3 reads the live line level.
- R13: Writing command bit 5 = 1 returns every register and flag to its reset value and aborts any sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, which triggers read side effects |
| addr | input | 3+ADDR_SHIFT | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by `addr` |
| bus_in | input | 1 | Sampled level of the one-wire line |
| bus_pull_o | output | 1 | 1 pulls the open-drain line low |
| irq_o | output | 1 | Interrupt output with programmable polarity |

## Verification
The bench builds the block with ADDR_SHIFT = 1, so the ignored low address bit is exercised. It also shrinks the timing parameters to a 40-tick reset low, 12-tick and 2-tick slot lows, an 18-tick slot and an overdrive shift of 1. With those values, complete reset and byte sequences take a few hundred clocks each when the divisor is zero. That leaves room in the run for a divided time base (N = 2, P = 1) and for overdrive timing. A bench slave model answers presence and pulls zero bits low, so both responding and silent buses are covered.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int unsigned IDX_CMD  = 0;
    localparam int unsigned IDX_DATA = 1;
    localparam int unsigned IDX_STAT = 2;
    localparam int unsigned IDX_IEN  = 3;
    localparam int unsigned IDX_DIV  = 4;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RST  = 2'd1,
        ENG_SLOT = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic       od;
        logic       dq;
        logic       rst_req;
        logic [6:0] ien;
        logic [4:0] div;
        logic [7:0] txbuf;
        logic       tx_full;
        logic [7:0] rxbuf;
        logic       rbf;
        logic       rsrf;
        logic       pd;
        logic       pdr;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_INIT = '{pdr: 1'b1, default: '0};

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int NW    = DIV_W - 2;
    localparam int CNT_W = NW + 3;

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim    = ((CNT_W'(div_i[NW-1:0]) + 1'b1) << div_i[DIV_W-1:NW]) - 1'b1;
        tick_o = run_i && (cnt_q == lim);
        if (!run_i || cnt_q == lim) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/owm_engine.sv
module owm_engine
    import owm_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_RST_HIGH = 625,
    parameter int T_PD_SMP   = 70,
    parameter int T_PD_DONE  = 300,
    parameter int T_W0       = 60,
    parameter int T_W1       = 6,
    parameter int T_SMP      = 15,
    parameter int T_SLOT     = 65,
    parameter int T_REC      = 5,
    parameter int OD_SHIFT   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       tick_i,
    input  logic       od_i,
    input  logic       bus_in_i,
    input  logic       start_rst_i,
    input  logic       start_byte_i,
    input  logic [7:0] tx_byte_i,
    output logic       busy_o,
    output logic       in_rst_o,
    output logic       pull_o,
    output logic       pd_evt_o,
    output logic       pd_val_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int SPAN = (T_RST_LOW + T_RST_HIGH > T_SLOT + T_REC) ?
                          (T_RST_LOW + T_RST_HIGH) : (T_SLOT + T_REC);
    localparam int CW = $clog2(SPAN + 1);

    typedef struct packed {
        eng_state_t    st;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          pres;
    } eng_t;

    eng_t d, q;
    logic [CW-1:0] rl, rh, ps, pdn, w0, w1, smp, se, low;

    function automatic logic [CW-1:0] scl(input int t, input logic od);
        int v;
        v = od ? (t >>> OD_SHIFT) : t;
        return CW'(v);
    endfunction

    always_comb begin
        rl  = scl(T_RST_LOW, od_i);
        rh  = scl(T_RST_HIGH, od_i);
        ps  = scl(T_PD_SMP, od_i);
        pdn = scl(T_PD_DONE, od_i);
        w0  = scl(T_W0, od_i);
        w1  = scl(T_W1, od_i);
        smp = scl(T_SMP, od_i);
        se  = scl(T_SLOT + T_REC, od_i);
        low = q.sh[0] ? w1 : w0;
    end

    always_comb begin
        d        = q;
        pull_o   = 1'b0;
        pd_evt_o = 1'b0;
        done_o   = 1'b0;
        unique case (q.st)
            ENG_IDLE: begin
                if (start_rst_i) begin
                    d.st  = ENG_RST;
                    d.cnt = '0;
                end else if (start_byte_i) begin
                    d.st   = ENG_SLOT;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.sh   = tx_byte_i;
                end
            end
            ENG_RST: begin
                pull_o = q.cnt < rl;
                if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == rl + ps)         d.pres   = bus_in_i;
                    if (q.cnt == rl + pdn)        pd_evt_o = 1'b1;
                    if (q.cnt == rl + rh - 1'b1)  d.st     = ENG_IDLE;
                end
            end
            ENG_SLOT: begin
                pull_o = q.cnt < low;
                if (tick_i) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == smp) d.rx = {bus_in_i, q.rx[7:1]};
                    if (q.cnt == se - 1'b1) begin
                        d.cnt  = '0;
                        d.sh   = q.sh >> 1;
                        d.bitn = q.bitn + 1'b1;
                        if (q.bitn == 3'd7) begin
                            d.st   = ENG_IDLE;
                            done_o = 1'b1;
                        end
                    end
                end
            end
            default: d.st = ENG_IDLE;
        endcase
        if (clr_i) begin
            d.st     = ENG_IDLE;
            pd_evt_o = 1'b0;
            done_o   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = (q.st != ENG_IDLE);
    assign in_rst_o = (q.st == ENG_RST);
    assign pd_val_o = q.pres;
    assign rx_o     = q.rx;
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
    import owm_pkg::*;
#(
    parameter int ADDR_SHIFT = 0,
    parameter int T_RST_LOW  = 480,
    parameter int T_RST_HIGH = 625,
    parameter int T_PD_SMP   = 70,
    parameter int T_PD_DONE  = 300,
    parameter int T_W0       = 60,
    parameter int T_W1       = 6,
    parameter int T_SMP      = 15,
    parameter int T_SLOT     = 65,
    parameter int T_REC      = 5,
    parameter int OD_SHIFT   = 2,
    localparam int AW        = 3 + ADDR_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          bus_in,
    output logic          bus_pull_o,
    output logic          irq_o
);
    ctrl_regs_t d, q;
    logic [2:0] idx;
    logic       tick, eng_busy, eng_in_rst, eng_pull, pd_evt, pd_val, byte_done;
    logic [7:0] eng_rx, stat;
    logic       stat_rd, data_rd, soft_rst, start_rst, start_byte, force_drv, any_src;

    assign idx = addr[AW-1:ADDR_SHIFT];

    owm_tick #(.DIV_W(5)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(eng_busy), .div_i(q.div), .tick_o(tick)
    );

    owm_engine #(
        .T_RST_LOW(T_RST_LOW), .T_RST_HIGH(T_RST_HIGH), .T_PD_SMP(T_PD_SMP),
        .T_PD_DONE(T_PD_DONE), .T_W0(T_W0), .T_W1(T_W1), .T_SMP(T_SMP),
        .T_SLOT(T_SLOT), .T_REC(T_REC), .OD_SHIFT(OD_SHIFT)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .tick_i(tick), .od_i(q.od),
        .bus_in_i(bus_in), .start_rst_i(start_rst), .start_byte_i(start_byte),
        .tx_byte_i(q.txbuf), .busy_o(eng_busy), .in_rst_o(eng_in_rst),
        .pull_o(eng_pull), .pd_evt_o(pd_evt), .pd_val_o(pd_val),
        .done_o(byte_done), .rx_o(eng_rx)
    );

    always_comb begin
        stat_rd    = rd_en && (idx == 3'(IDX_STAT));
        data_rd    = rd_en && (idx == 3'(IDX_DATA));
        soft_rst   = wr_en && (idx == 3'(IDX_CMD)) && wdata[5];
        start_rst  = q.rst_req && !eng_busy;
        start_byte = q.tx_full && !eng_busy && !q.rst_req && !q.rsrf;
        force_drv  = q.dq && q.ien[6];
        stat       = {2'b00, q.rsrf, q.rbf, !(eng_busy && !eng_in_rst), !q.tx_full, q.pdr, q.pd};
        any_src    = |(stat[5:0] & {q.ien[5:2], 1'b0, q.ien[0]});
        irq_o      = q.ien[1] ? any_src : !any_src;
        bus_pull_o = eng_pull || force_drv;
    end

    always_comb begin
        unique case (idx)
            3'(IDX_CMD):  rdata = {q.od, 3'b000, bus_in, q.dq, 1'b0, q.rst_req || eng_in_rst};
            3'(IDX_DATA): rdata = q.rxbuf;
            3'(IDX_STAT): rdata = stat;
            3'(IDX_IEN):  rdata = {1'b0, q.ien};
            3'(IDX_DIV):  rdata = {3'b000, q.div};
            default:      rdata = 8'h00;
        endcase
    end

    always_comb begin
        d = q;
        if (start_rst)       d.rst_req = 1'b0;
        else if (start_byte) d.tx_full = 1'b0;
        if (stat_rd) d.pd = 1'b0;
        if (pd_evt) begin
            d.pd  = 1'b1;
            d.pdr = pd_val;
        end
        if (data_rd) begin
            if (q.rsrf) begin
                d.rxbuf = eng_rx;
                d.rsrf  = 1'b0;
            end else begin
                d.rbf = 1'b0;
            end
        end
        if (byte_done) begin
            if (d.rbf) begin
                d.rsrf = 1'b1;
            end else begin
                d.rxbuf = eng_rx;
                d.rbf   = 1'b1;
            end
        end
        if (wr_en) begin
            unique case (idx)
                3'(IDX_CMD): begin
                    d.od = wdata[7];
                    d.dq = wdata[2];
                    if (wdata[0]) d.rst_req = 1'b1;
                end
                3'(IDX_DATA): begin
                    d.txbuf   = wdata;
                    d.tx_full = 1'b1;
                end
                3'(IDX_IEN): d.ien = wdata[6:0];
                3'(IDX_DIV): d.div = wdata[4:0];
                default: ;
            endcase
        end
        if (soft_rst) d = CTRL_INIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_INIT;
        else        q <= d;
    end
endmodule

// File: rtl/owm_ctrl_chk.sv
module owm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_pull_o,
    input logic       irq_o,
    input logic       eng_busy,
    input logic       force_drv,
    input logic [6:0] ien,
    input logic       rbf,
    input logic       rsrf,
    input logic       pd,
    input logic       stat_rd
);
    // R8
    rsrf_needs_rbf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsrf |-> rbf);

    // R12
    pull_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_o |-> (eng_busy || force_drv));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 7'd0) |-> irq_o);

    // R5
    pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !eng_busy) |=> !pd);

    // R6
    seq_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> bus_pull_o);
endmodule

bind owm_ctrl owm_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_pull_o(bus_pull_o), .irq_o(irq_o),
    .eng_busy(eng_busy), .force_drv(force_drv), .ien(q.ien), .rbf(q.rbf),
    .rsrf(q.rsrf), .pd(q.pd), .stat_rd(stat_rd)
);

// File: tb/owm_ctrl_test.sv
module owm_ctrl_test;
    localparam int SH = 1, RL = 40, RH = 60, PS = 10, PDN = 30;
    localparam int W0 = 12, W1 = 2, SMP = 5, SLT = 16, REC = 2, ODS = 1;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       bus_pull, irq, slv_pull = 1'b0;
    logic       line;
    assign line = ~(bus_pull | slv_pull);

    always #4 clk = ~clk;

    owm_ctrl #(.ADDR_SHIFT(SH), .T_RST_LOW(RL), .T_RST_HIGH(RH), .T_PD_SMP(PS),
               .T_PD_DONE(PDN), .T_W0(W0), .T_W1(W1), .T_SMP(SMP), .T_SLOT(SLT),
               .T_REC(REC), .OD_SHIFT(ODS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bus_in(line), .bus_pull_o(bus_pull), .irq_o(irq)
    );

    int checks = 0, errors = 0;
    int exp_q[$];
    bit mon_skip = 1'b0, finished = 1'b0;
    bit slv_present = 1'b0;
    logic [7:0] slv_byte = 8'hFF;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compares each low pulse of the master against the scoreboard.
    int plen = 0;
    always @(negedge clk) begin
        if (bus_pull) plen++;
        else if (plen > 0) begin
            if (!mon_skip) begin
                if (exp_q.size() == 0) chk("R3 R6 unexpected pulse", plen, 0);
                else chk("R3 R6 R10 R11 pulse length", plen, exp_q.pop_front());
            end
            plen = 0;
        end
    end

    // Slave model on the line.
    bit prev = 1'b0;
    int mlen = 0, hold = 0, wait_c = 0;
    int sidx = 0;
    always @(negedge clk) begin
        if (bus_pull && !prev) begin
            if (!slv_byte[sidx[2:0]]) hold = 8;
            sidx = (sidx + 1) % 8;
            mlen = 0;
        end
        if (bus_pull) mlen++;
        if (!bus_pull && prev && mlen >= 16) begin
            sidx = 0;
            hold = 0;
            if (slv_present) wait_c = 3;
        end
        if (wait_c > 0) begin
            wait_c--;
            if (wait_c == 0) hold = 15;
        end
        slv_pull = (hold > 0);
        if (hold > 0) hold--;
        prev = bus_pull;
    end

    task automatic wr_raw(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic rd_raw(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask
    task automatic wr(input int i, input logic [7:0] v);
        wr_raw(4'(i << SH), v);
    endtask
    task automatic rd(input int i, output logic [7:0] v);
        rd_raw(4'(i << SH), v);
    endtask
    task automatic wait_rst();
        logic [7:0] v;
        do rd(0, v); while (v[0]);
    endtask
    task automatic wait_bytes();
        logic [7:0] v;
        do rd(2, v); while (!(v[3] && v[2]));
    endtask
    task automatic send(input logic [7:0] b, input bit od);
        for (int i = 0; i < 8; i++)
            exp_q.push_back(b[i] ? (od ? (W1 >> ODS) : W1) : (od ? (W0 >> ODS) : W0));
        wr(1, b);
    endtask
    task automatic bus_reset(input bit od, input int mult);
        exp_q.push_back((od ? (RL >> ODS) : RL) * mult);
        wr(0, od ? 8'h81 : 8'h01);
        wait_rst();
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog actual %0d expected done", cyc);
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(2, v); chk("R2 status", v, 8'h0E);
        chk("R2 irq", irq, 1);
        rd(0, v); chk("R2 R12 cmd line level", v, 8'h08);
        rd(4, v); chk("R2 divisor", v, 0);

        // R1 address spacing and divisor width
        wr_raw(4'd9, 8'hFF);
        rd_raw(4'd8, v); chk("R1 divisor via shifted address", v, 8'h1F);
        rd_raw(4'd10, v); chk("R1 unused index", v, 0);
        wr(4, 8'h00);

        // R3 R4 R5 reset with a slave
        slv_present = 1'b1;
        exp_q.push_back(RL);
        wr(0, 8'h01);
        rd(0, v); chk("R3 reset busy bit", v[0], 1);
        wait_rst();
        rd(2, v); chk("R4 presence answered", v, 8'h0D);
        rd(2, v); chk("R5 read clears done only", v, 8'h0C);

        // R4 reset without a slave
        slv_present = 1'b0;
        bus_reset(1'b0, 1);
        rd(2, v); chk("R4 no presence", v, 8'h0F);
        rd(2, v); chk("R4 result held", v, 8'h0E);

        // R9 interrupt polarity and masking
        wr(3, 8'h03);
        chk("R9 active-high idle", irq, 0);
        slv_present = 1'b1;
        bus_reset(1'b0, 1);
        chk("R9 presence raises irq", irq, 1);
        rd(2, v);
        chk("R9 cleared after status read", irq, 0);
        wr(3, 8'h08); chk("R9 active-low shift idle", irq, 0);
        wr(3, 8'h00); chk("R9 nothing enabled", irq, 1);

        // R6 R7 write slots
        slv_byte = 8'hFF;
        send(8'hA5, 1'b0);
        wait_bytes();
        rd(2, v); chk("R8 rx buffer full", v, 8'h1C);
        rd(1, v); chk("R7 echoed byte", v, 8'hA5);
        rd(2, v); chk("R8 rx buffer drained", v, 8'h0C);

        // R7 read by all-ones
        slv_byte = 8'h3C;
        send(8'hFF, 1'b0);
        wait_bytes();
        rd(1, v); chk("R7 slave byte", v, 8'h3C);
        slv_byte = 8'hFF;

        // R8 queued byte and shift-register hold
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        rd(2, v); chk("R8 tx buffer occupied", v[2], 0);
        wait_bytes();
        rd(2, v); chk("R8 both rx stages full", v, 8'h3C);
        rd(1, v); chk("R8 first byte", v, 8'h11);
        rd(2, v); chk("R8 refill from shift", v, 8'h1C);
        rd(1, v); chk("R8 second byte", v, 8'h22);
        rd(2, v); chk("R8 all drained", v, 8'h0C);

        // R11 overdrive
        wr(0, 8'h80);
        bus_reset(1'b1, 1);
        rd(2, v); chk("R11 overdrive presence", v, 8'h0D);
        send(8'h01, 1'b1);
        wait_bytes();
        rd(1, v); chk("R11 overdrive byte", v, 8'h01);
        wr(0, 8'h00);

        // R12 direct line drive
        wr(3, 8'h00); wr(0, 8'h04);
        chk("R12 drive gated off", bus_pull, 0);
        rd(0, v); chk("R12 cmd readback line high", v, 8'h0C);
        mon_skip = 1'b1;
        wr(3, 8'h40);
        chk("R12 drive enabled", bus_pull, 1);
        rd(0, v); chk("R12 cmd readback line low", v, 8'h04);
        wr(0, 8'h00); wr(3, 8'h00);
        repeat (2) @(negedge clk);
        mon_skip = 1'b0;

        // R10 divided time base: N=2, P=1 gives 6 clocks per tick
        wr(4, 8'h0A);
        slv_present = 1'b0;
        bus_reset(1'b0, 6);
        rd(2, v); chk("R10 divided reset done", v, 8'h0F);

        // R13 soft reset
        wr(3, 8'h13);
        wr(0, 8'h20);
        rd(4, v); chk("R13 divisor cleared", v, 0);
        rd(3, v); chk("R13 enable cleared", v, 0);
        rd(2, v); chk("R13 status restored", v, 8'h0E);

        repeat (4) @(negedge clk);
        chk("R6 all expected pulses seen", exp_q.size(), 0);
        summary();
    end
endmodule